// File: doc/BRIEF.md
# USB Low/Full-Speed Line Receiver

This block recovers the bit stream from the two data lines of a low-speed or full-speed USB link. A free-running sample clock runs at a fixed multiple of the bit rate. Each line passes through a two-flop synchroniser, and the pair is then classified as one of four line symbols. A speed-select input chooses which of the two differential states counts as J. The other is K.

While the link is idle, the first J-to-K change marks start of packet. All later sample points are placed by counting sample clocks from that instant, at the centre of each bit period. The sampled symbols are NRZI-decoded. Zeros inserted after six ones are removed and flagged. A single-ended zero followed by J closes the packet. The outputs are single-cycle strobes: data bits, stuff bits, start of packet, end of packet and line errors. The classified line symbol is also available as an output.

Top module: `usbrx_receiver`

## Requirements
- R1: D+ and D- each pass through two synchroniser flops. `line_sym_o` shows the classified symbol of the line values captured two rising edges earlier. The codes are SE0=0, J=1, K=2 and SE1=3. {D+,D-}=00 is SE0 and 11 is SE1 in both speeds.
- R2: In idle, a classified symbol of K that directly follows J raises `sop_o` for one cycle. A K that follows SE0 or SE1 starts nothing.
- R3: With P = CLKS_PER_BIT, the n-th sample of a packet is taken P/2 + n*P clocks after the cycle in which `sop_o` is high. Every data, stuff, end or error pulse appears exactly that many cycles after `sop_o`, with no re-alignment on later line edges. The symbol that caused SOP is sample 0.
- R4: NRZI decoding: a sampled J or K equal to the previous sampled symbol gives data 1, and a different one gives data 0. The previous symbol is J at SOP. Data bits come out on `bit_data_o`, qualified by a one-cycle `bit_valid_o`.
- R5: A 0 sampled after six consecutive 1s is a stuff bit. It pulses `stuff_o`, produces no `bit_valid_o`, and restarts the count of ones.
- R6: A data 0 restarts the count of consecutive ones, so ones separated by a 0 never add up to a stuff condition.
- R7: Sampling SE0 in a packet produces no data bit and begins the end phase. Further SE0 samples keep the end phase. A J sample after SE0 pulses `eop_o` and returns the block to idle.
- R8: An SE1 sample inside a packet, or a K or SE1 sample during the end phase, pulses `err_o` and returns the block to idle. At most one of the five strobes is high in any cycle.
- R9: The reset is synchronous and active low. While `rst_n` is low, all strobes are 0. After reset the block is idle, with the previous symbol taken as J.
- R10: With `low_speed_i`=0, {D+,D-}=10 is J and 01 is K. With `low_speed_i`=1 the two are swapped.
- R11: When SE0 is sampled where a stuff bit was due (after six ones), the end phase takes precedence. No stuff pulse and no error occur, and the packet ends normally on the following J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, CLKS_PER_BIT cycles per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| low_speed_i | input | 1 | 1 selects the low-speed J/K assignment |
| line_sym_o | output | 2 | Classified line symbol (0 SE0, 1 J, 2 K, 3 SE1) |
| bit_valid_o | output | 1 | One-cycle strobe for a decoded data bit |
| bit_data_o | output | 1 | Decoded data bit, valid with bit_valid_o |
| stuff_o | output | 1 | One-cycle strobe for a removed stuff bit |
| sop_o | output | 1 | One-cycle strobe at start of packet |
| eop_o | output | 1 | One-cycle strobe at end of packet |
| err_o | output | 1 | One-cycle strobe on an illegal symbol in a packet |

## Verification
Two functions can claim the same sample point. After six equal symbols the stuffing rule expects a zero, and if SE0 arrives in that slot, end-of-packet handling wants the same sample. A packet of six ones that ends directly in SE0 SE0 J provokes this. It is judged by requiring no stuff strobe, no error, seven data bits and a normal end strobe. A second collision arises when an error and the return to idle fall on the same sample. This is judged by requiring that the next packet starts cleanly from the next J-to-K change. Every strobe's distance from `sop_o` is checked against the half-bit-plus-whole-bits rule.

// File: rtl/usbrx_pkg.sv
// Package: shared types for the USB low/full-speed line receiver.
// Assumes: symbol codes are visible on the top-level symbol output.
package usbrx_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2,
        SYM_SE1 = 2'd3
    } usb_sym_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_END  = 2'd2
    } rx_state_t;

endpackage

// File: rtl/usbrx_line_sync.sv
// Module: usbrx_line_sync
// Synchronises D+ and D- through SYNC_STAGES flops each, then classifies
// the synchronised pair into a line symbol using the speed select.
// Assumes: the speed select is quasi-static and changes only while the
// line shows SE0 or while the receiver is held in reset.
module usbrx_line_sync
    import usbrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dp_i,
    input  logic     dm_i,
    input  logic     low_speed_i,
    output usb_sym_t sym_o
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;

    assign raw = {dp_i, dm_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain_q;

        // Shift the line value through its synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], raw[g]};
        end

        assign synced[g] = chain_q[SYNC_STAGES-1];
    end

    // Map the synchronised {D+,D-} pair to a symbol for the selected speed.
    always_comb begin
        unique case (synced)
            2'b00:   sym_o = SYM_SE0;
            2'b11:   sym_o = SYM_SE1;
            2'b10:   sym_o = low_speed_i ? SYM_K : SYM_J;
            default: sym_o = low_speed_i ? SYM_J : SYM_K;
        endcase
    end

endmodule

// File: rtl/usbrx_bit_timer.sv
// Module: usbrx_bit_timer
// Places sample points at the centre of each bit, counted from the
// start-of-packet cycle. It never re-aligns to later line edges.
// Assumes: CLKS_PER_BIT >= 4.
module usbrx_bit_timer #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic strobe_o
);

    localparam int            CW   = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 2;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2);

    logic [CW-1:0] phase_q;

    // Track the clocks elapsed within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (start_i)          phase_q <= CW'(1);
        else if (run_i)            phase_q <= (phase_q == LAST) ? '0 : phase_q + CW'(1);
    end

    assign strobe_o = run_i && (phase_q == HALF);

    // R3
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/usbrx_nrzi_destuff.sv
// Module: usbrx_nrzi_destuff
// NRZI-decodes sampled J/K symbols and removes the zero that follows
// six consecutive ones. Its outputs are registered one-cycle strobes.
// Assumes: sample_i is high only for J or K symbols inside a packet.
module usbrx_nrzi_destuff
    import usbrx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear_i,
    input  logic     sample_i,
    input  usb_sym_t sym_i,
    output logic     bit_valid_o,
    output logic     bit_data_o,
    output logic     stuff_o
);

    localparam int            OW      = $clog2(STUFF_RUN + 2);
    localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN + 1);
    localparam logic [OW-1:0] RUN_LEN = OW'(STUFF_RUN);

    usb_sym_t      prev_q;
    logic [OW-1:0] ones_q;
    logic          same;

    assign same = (sym_i == prev_q);

    // Decode one sample: emit a data bit or drop a stuff bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= SYM_J;
            ones_q      <= '0;
            bit_valid_o <= 1'b0;
            bit_data_o  <= 1'b0;
            stuff_o     <= 1'b0;
        end else begin
            bit_valid_o <= 1'b0;
            stuff_o     <= 1'b0;
            if (clear_i) begin
                prev_q <= SYM_J;
                ones_q <= '0;
            end else if (sample_i) begin
                prev_q <= sym_i;
                if (!same && ones_q == RUN_LEN) begin
                    stuff_o <= 1'b1;
                    ones_q  <= '0;
                end else begin
                    bit_valid_o <= 1'b1;
                    bit_data_o  <= same;
                    if (!same)                ones_q <= '0;
                    else if (ones_q != RUN_MAX) ones_q <= ones_q + OW'(1);
                end
            end
        end
    end

    // R5
    stuff_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_o |-> ($past(ones_q) == RUN_LEN) && (ones_q == '0));

    // R6
    zero_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && !bit_data_o) |-> (ones_q == '0));

endmodule

// File: rtl/usbrx_receiver.sv
// Module: usbrx_receiver (top)
// Receives a low- or full-speed USB packet from D+/D-. It detects the
// start of packet, samples at bit centres, decodes NRZI, removes stuff
// bits and detects the end of packet. Every output is a one-cycle strobe.
// Assumes: clk runs at CLKS_PER_BIT times the selected bit rate.
module usbrx_receiver
    import usbrx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int STUFF_RUN    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_i,
    input  logic       dm_i,
    input  logic       low_speed_i,
    output logic [1:0] line_sym_o,
    output logic       bit_valid_o,
    output logic       bit_data_o,
    output logic       stuff_o,
    output logic       sop_o,
    output logic       eop_o,
    output logic       err_o
);

    usb_sym_t  sym;
    usb_sym_t  idle_last_q;
    rx_state_t state_q;
    logic      strobe;
    logic      sop_det;
    logic      data_sample;

    usbrx_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .dp_i        (dp_i),
        .dm_i        (dm_i),
        .low_speed_i (low_speed_i),
        .sym_o       (sym)
    );

    usbrx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (sop_det),
        .run_i    (state_q != ST_IDLE),
        .strobe_o (strobe)
    );

    usbrx_nrzi_destuff #(.STUFF_RUN(STUFF_RUN)) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (sop_det),
        .sample_i    (data_sample),
        .sym_i       (sym),
        .bit_valid_o (bit_valid_o),
        .bit_data_o  (bit_data_o),
        .stuff_o     (stuff_o)
    );

    assign line_sym_o = sym;

    // Find the idle J-to-K change and qualify data samples.
    always_comb begin
        sop_det     = (state_q == ST_IDLE) && (idle_last_q == SYM_J) && (sym == SYM_K);
        data_sample = strobe && (state_q == ST_BITS) && (sym == SYM_J || sym == SYM_K);
    end

    // Packet state machine, with registered start, end and error strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idle_last_q <= SYM_J;
            sop_o       <= 1'b0;
            eop_o       <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            sop_o <= 1'b0;
            eop_o <= 1'b0;
            err_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    idle_last_q <= sym;
                    if (sop_det) begin
                        state_q <= ST_BITS;
                        sop_o   <= 1'b1;
                    end
                end
                ST_BITS: begin
                    if (strobe && sym == SYM_SE0) begin
                        state_q <= ST_END;
                    end else if (strobe && sym == SYM_SE1) begin
                        state_q     <= ST_IDLE;
                        idle_last_q <= sym;
                        err_o       <= 1'b1;
                    end
                end
                ST_END: begin
                    if (strobe && sym != SYM_SE0) begin
                        state_q     <= ST_IDLE;
                        idle_last_q <= sym;
                        eop_o       <= (sym == SYM_J);
                        err_o       <= (sym != SYM_J);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sop_o, bit_valid_o, stuff_o, eop_o, err_o}));

    // R2
    sop_enters_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sop_o |-> (state_q == ST_BITS));

    // R7
    end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_o || err_o) |-> (state_q == ST_IDLE));

endmodule

// File: tb/usbrx_receiver_test.sv
// Bench for usbrx_receiver. It walks a table of packets, then runs
// directed tests for reset, synchroniser latency, speed and SOP rules.
module usbrx_receiver_test;

    localparam int P    = 8;
    localparam int HALF = P / 2;
    localparam int NV   = 8;
    localparam logic [1:0] C_SE0 = 2'd0, C_J = 2'd1, C_K = 2'd2, C_SE1 = 2'd3;

    // Symbol i of a packet sits at bits [2i+1:2i]: 0 SE0, 1 J, 2 K, 3 SE1.
    localparam logic [31:0] TBL_SYM  [NV] = '{32'h0010A666, 32'h0010A666, 32'h00416AAA,
                                              32'h125556AA, 32'h000001E6, 32'h00000186,
                                              32'h00416AAA, 32'h00042AAA};
    localparam int          TBL_N    [NV] = '{11, 11, 12, 15, 5, 5, 12, 10};
    localparam bit          TBL_LS   [NV] = '{0, 1, 0, 0, 0, 0, 1, 0};
    localparam int          TBL_NB   [NV] = '{8, 8, 8, 12, 3, 2, 8, 7};
    localparam logic [15:0] TBL_BITS [NV] = '{16'h0080, 16'h0080, 16'h00FE, 16'h0FDE,
                                              16'h0000, 16'h0000, 16'h00FE, 16'h007E};
    localparam int          TBL_ST   [NV] = '{0, 0, 1, 1, 0, 0, 1, 0};
    localparam int          TBL_EOP  [NV] = '{1, 1, 1, 1, 0, 0, 1, 1};
    localparam int          TBL_ERR  [NV] = '{0, 0, 0, 0, 1, 1, 0, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b1, dm = 1'b0, ls = 1'b0;
    logic [1:0] line_sym;
    logic       bit_valid, bit_data, stuff, sop, eop, err;

    int checks = 0, fails = 0;
    int since = 1000000, nbits = 0, n_stuff = 0, n_sop = 0, n_eop = 0, n_err = 0;
    logic [15:0] rx_bits = '0;
    bit timing_bad = 1'b0;

    always #5 clk = ~clk;

    usbrx_receiver #(.CLKS_PER_BIT(P)) uut (
        .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .low_speed_i(ls),
        .line_sym_o(line_sym), .bit_valid_o(bit_valid), .bit_data_o(bit_data),
        .stuff_o(stuff), .sop_o(sop), .eop_o(eop), .err_o(err));

    // Collect strobes away from the active edge and check the R3 spacing.
    always @(negedge clk) begin
        if (sop) begin
            since = 0;
            n_sop++;
        end else begin
            since++;
        end
        if (bit_valid || stuff || eop || err) begin
            if ((since - HALF) % P != 0 || since < HALF) timing_bad = 1'b1;
        end
        if (bit_valid) begin
            if (nbits < 16) rx_bits[nbits] = bit_data;
            nbits++;
        end
        if (stuff) n_stuff++;
        if (eop)   n_eop++;
        if (err)   n_err++;
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_mon();
        nbits = 0; n_stuff = 0; n_sop = 0; n_eop = 0; n_err = 0;
        rx_bits = '0; timing_bad = 1'b0;
    endtask

    task automatic drive_sym(input logic [1:0] code);
        unique case (code)
            C_SE0:   {dp, dm} = 2'b00;
            C_SE1:   {dp, dm} = 2'b11;
            C_J:     {dp, dm} = ls ? 2'b01 : 2'b10;
            default: {dp, dm} = ls ? 2'b10 : 2'b01;
        endcase
        repeat (P) @(negedge clk);
    endtask

    task automatic set_speed(input logic v);
        drive_sym(C_SE0);
        ls = v;
        repeat (3) drive_sym(C_J);
    endtask

    initial begin
        #(10 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: strobes stay low while reset is held.
        repeat (4) @(negedge clk);
        check({sop, bit_valid, stuff, eop, err} == 5'b0, "R9 strobes in reset",
              {sop, bit_valid, stuff, eop, err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(line_sym == C_J, "R9 R10 idle symbol after reset", line_sym, C_J);

        // R1: two synchroniser stages before the symbol changes.
        {dp, dm} = 2'b00;
        @(negedge clk);
        check(line_sym == C_J, "R1 symbol held after one edge", line_sym, C_J);
        @(negedge clk);
        check(line_sym == C_SE0, "R1 symbol after two edges", line_sym, C_SE0);

        // R2: SE0 followed by K does not start a packet.
        clear_mon();
        repeat (P) @(negedge clk);
        repeat (2) drive_sym(C_K);
        repeat (3) drive_sym(C_J);
        check(n_sop == 0, "R2 no SOP from SE0 to K", n_sop, 0);
        check(n_err + nbits == 0, "R2 no activity after SE0 to K", n_err + nbits, 0);

        // Table walk: R3 R4 R5 R6 R7 R8 R10 R11.
        for (int e = 0; e < NV; e++) begin
            if (ls != TBL_LS[e]) set_speed(TBL_LS[e]);
            clear_mon();
            for (int i = 0; i < TBL_N[e]; i++) drive_sym(TBL_SYM[e][2*i +: 2]);
            repeat (4) drive_sym(C_J);
            check(n_sop == 1, $sformatf("R2 sop count pkt%0d", e), n_sop, 1);
            check(nbits == TBL_NB[e], $sformatf("R4 R7 bit count pkt%0d", e), nbits, TBL_NB[e]);
            check(rx_bits == TBL_BITS[e], $sformatf("R4 R10 data bits pkt%0d", e), rx_bits, TBL_BITS[e]);
            check(n_stuff == TBL_ST[e], $sformatf("R5 R6 R11 stuff count pkt%0d", e), n_stuff, TBL_ST[e]);
            check(n_eop == TBL_EOP[e], $sformatf("R7 eop count pkt%0d", e), n_eop, TBL_EOP[e]);
            check(n_err == TBL_ERR[e], $sformatf("R8 err count pkt%0d", e), n_err, TBL_ERR[e]);
            check(!timing_bad, $sformatf("R3 sample spacing pkt%0d", e), timing_bad, 0);
        end

        // R10: low-speed maps {D+,D-}=10 to K.
        set_speed(1'b1);
        {dp, dm} = 2'b10;
        repeat (3) @(negedge clk);
        check(line_sym == C_K, "R10 low-speed 10 is K", line_sym, C_K);
        {dp, dm} = 2'b01;
        repeat (3) @(negedge clk);
        check(line_sym == C_J, "R10 low-speed 01 is J", line_sym, C_J);

        // R9: reset in mid-packet, then a clean packet decodes.
        ls = 1'b0;
        rst_n = 1'b0;
        drive_sym(C_J);
        rst_n = 1'b1;
        repeat (3) drive_sym(C_J);
        drive_sym(C_K);
        drive_sym(C_J);
        rst_n = 1'b0;
        {dp, dm} = 2'b10;
        repeat (2) @(negedge clk);
        check({sop, bit_valid, stuff, eop, err} == 5'b0, "R9 strobes in mid-packet reset",
              {sop, bit_valid, stuff, eop, err}, 0);
        rst_n = 1'b1;
        repeat (3) drive_sym(C_J);
        clear_mon();
        for (int i = 0; i < TBL_N[0]; i++) drive_sym(TBL_SYM[0][2*i +: 2]);
        repeat (4) drive_sym(C_J);
        check(rx_bits == TBL_BITS[0] && nbits == TBL_NB[0], "R9 packet after reset",
              rx_bits, TBL_BITS[0]);
        check(n_eop == 1 && n_err == 0, "R9 R7 end after reset", n_eop, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule